// File: doc/BRIEF.md
# Switch Packet Header Parser

This block walks a fixed graph of header states over a byte-wide packet stream in a switch pipeline. Each packet starts with a 16-byte metadata prefix written by the switch front end. The parser skips this prefix, but it keeps two values from it: a selector byte and the 9-bit ingress port. These two values decide whether a 2-byte injected header or a 2-byte CPU-bound header comes before the Ethernet header. The parser then follows the EtherType into IPv4, and the IPv4 protocol field into TCP or UDP.

Each header is captured whole into its own output register, in network byte order. A validity byte records which headers were received completely. When the header walk ends, a one-cycle done pulse comes out together with the number of header bytes consumed. If the stream stops before the graph is finished, an error flag is raised as well.

Payload bytes after the last header are ignored until the next start-of-packet. The source can pause the stream at any time by dropping valid.

Top module: `hp_parser`

## Requirements
- R1: After reset, the validity byte, done, error and the parsed length are all zero.
- R2: The first 16 bytes of a packet form a prefix that is consumed without branching. When the prefix completes, validity bit 6 is set. If prefix byte 12 is zero, a 2-byte injected header follows (validity bit 0, captured on `hdr_inj`) and then Ethernet.
- R3: If prefix byte 12 is non-zero, the ingress port is taken as {bit 0 of prefix byte 0, prefix byte 1}. Port 320 selects a 2-byte CPU-bound header (validity bit 1, captured on `hdr_cpu`) followed by Ethernet. Any other port goes directly to Ethernet.
- R4: Ethernet takes 14 bytes and sets validity bit 2. The EtherType is held in its bytes 12 and 13. A value of 0x0800 leads to IPv4; any other value ends the walk.
- R5: IPv4 takes 20 bytes and sets validity bit 3. Protocol byte 9 equal to 6 leads to TCP (20 bytes, bit 4), and equal to 17 leads to UDP (8 bytes, bit 5). Either branch is taken only when the 13-bit fragment offset (the low 5 bits of byte 6 followed by byte 7) is zero. Otherwise the walk ends.
- R6: Each header output holds its bytes in network order: the first byte received sits in the most significant 8 bits.
- R7: `done` is a one-cycle pulse, exactly once per packet. It appears in the cycle after the last header byte is accepted. At that moment `parse_len` holds the number of header bytes consumed, prefix included.
- R8: If end-of-packet comes while the graph still needs bytes, `done` and `parse_err` pulse together. Headers that were not completed keep their validity bits clear, and `parse_len` equals the number of bytes received.
- R9: When valid is low, the walk position is held. Bytes that arrive after the walk has ended, or without a start-of-packet, change no output.
- R10: A start-of-packet beat clears the validity byte. In the following cycle the validity byte reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_byte | input | 8 | Stream data |
| hdr_vld | output | 8 | Validity byte, one bit per completed header |
| hdr_inj | output | 16 | Injected header |
| hdr_cpu | output | 16 | CPU-bound header |
| hdr_eth | output | 112 | Ethernet header |
| hdr_ipv4 | output | 160 | IPv4 header |
| hdr_tcp | output | 160 | TCP header |
| hdr_udp | output | 64 | UDP header |
| done | output | 1 | End-of-walk pulse |
| parse_err | output | 1 | Stream ended before the walk finished |
| parse_len | output | 16 | Header bytes consumed |

## Verification
Two events can fall on the same beat: the completion of a header and the end of the stream. Which of them wins decides between a clean finish and an error.

The bench provokes both outcomes. In one packet, end-of-packet arrives on the final byte of a UDP header, which is a terminal header; the expected result is done with no error. In another, end-of-packet arrives on the final byte of an Ethernet header with EtherType 0x0800, which still needs IPv4; the expected result is done and error together, with the Ethernet validity bit set.

A scoreboard model, built from the requirements, predicts the validity byte, the length and the error flag for every packet, including the stall and truncation cases.

// File: rtl/hp_pkg.sv
// Shared types and constants for the header parser.
// Assumes a byte-wide stream; header lengths are fixed by the graph.
package hp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_META, ST_INJ, ST_CPU, ST_ETH,
        ST_IPV4, ST_TCP, ST_UDP, ST_DRAIN
    } hp_state_e;

    localparam int unsigned LEN_INJ  = 2;
    localparam int unsigned LEN_CPU  = 2;
    localparam int unsigned LEN_ETH  = 14;
    localparam int unsigned LEN_IPV4 = 20;
    localparam int unsigned LEN_TCP  = 20;
    localparam int unsigned LEN_UDP  = 8;

    localparam int unsigned PROTO_BIT = 72;
    localparam int unsigned FRAG_BIT  = 51;
    localparam int unsigned FRAG_W    = 13;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    // Length in bytes of the header a state consumes (1 for non-header states).
    function automatic int unsigned hdr_len(hp_state_e s, int unsigned meta_bytes);
        case (s)
            ST_META: return meta_bytes;
            ST_INJ:  return LEN_INJ;
            ST_CPU:  return LEN_CPU;
            ST_ETH:  return LEN_ETH;
            ST_IPV4: return LEN_IPV4;
            ST_TCP:  return LEN_TCP;
            ST_UDP:  return LEN_UDP;
            default: return 1;
        endcase
    endfunction

    // Validity bit owned by a header state.
    function automatic logic [7:0] vbit(hp_state_e s);
        case (s)
            ST_INJ:  return 8'h01;
            ST_CPU:  return 8'h02;
            ST_ETH:  return 8'h04;
            ST_IPV4: return 8'h08;
            ST_TCP:  return 8'h10;
            ST_UDP:  return 8'h20;
            ST_META: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/hp_capture.sv
// Header capture register: shifts in one byte per enabled beat, MSB first.
// Assumes the owner enables it only while its header is on the stream.
// q_next shows the register contents including the byte on din this beat.
module hp_capture #(
    parameter int unsigned BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [7:0]           din,
    output logic [8*BYTES-1:0]   q,
    output logic [8*BYTES-1:0]   q_next
);
    localparam int unsigned W = 8 * BYTES;

    generate
        if (BYTES > 1) begin : g_shift
            assign q_next = {q[W-9:0], din};
        end else begin : g_single
            assign q_next = din;
        end
    endgenerate

    // Load the shifted view on each enabled beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/hp_branch.sv
// Branch decision of the parse graph, evaluated on the beat that completes a header.
// Assumes each *_full input already includes the byte arriving this beat.
// Terminal outcomes are reported as ST_DRAIN.
module hp_branch
    import hp_pkg::*;
#(
    parameter int unsigned META_BYTES   = 16,
    parameter int unsigned SEL_BYTE     = 12,
    parameter int unsigned PORT_BIT_OFS = 7,
    parameter int unsigned PORT_W       = 9,
    parameter int unsigned CPU_PORT     = 320
) (
    input  hp_state_e                    cur,
    input  logic [8*META_BYTES-1:0]      meta_full,
    input  logic [8*LEN_ETH-1:0]         eth_full,
    input  logic [8*LEN_IPV4-1:0]        ipv4_full,
    output hp_state_e                    nxt
);
    localparam int unsigned MW      = 8 * META_BYTES;
    localparam int unsigned IW      = 8 * LEN_IPV4;
    localparam int unsigned SEL_HI  = MW - 1 - 8 * SEL_BYTE;
    localparam int unsigned PORT_HI = MW - 1 - PORT_BIT_OFS;

    logic [7:0]        sel;
    logic [PORT_W-1:0] port;
    logic [15:0]       etype;
    logic [7:0]        proto;
    logic [FRAG_W-1:0] frag;
    logic              unused_bits;

    assign sel   = meta_full[SEL_HI -: 8];
    assign port  = meta_full[PORT_HI -: PORT_W];
    assign etype = eth_full[15:0];
    assign proto = ipv4_full[IW-1-PROTO_BIT -: 8];
    assign frag  = ipv4_full[IW-1-FRAG_BIT -: FRAG_W];
    assign unused_bits = ^{meta_full, eth_full, ipv4_full};

    // Successor of the header that completes this beat.
    always_comb begin
        nxt = ST_DRAIN;
        case (cur)
            ST_META: begin
                if (sel == 8'd0)                     nxt = ST_INJ;
                else if (port == PORT_W'(CPU_PORT))  nxt = ST_CPU;
                else                                 nxt = ST_ETH;
            end
            ST_INJ, ST_CPU: nxt = ST_ETH;
            ST_ETH:  nxt = (etype == ETYPE_IPV4) ? ST_IPV4 : ST_DRAIN;
            ST_IPV4: begin
                if (frag == '0 && proto == PROTO_TCP)      nxt = ST_TCP;
                else if (frag == '0 && proto == PROTO_UDP) nxt = ST_UDP;
                else                                       nxt = ST_DRAIN;
            end
            default: nxt = ST_DRAIN;
        endcase
    end

endmodule

// File: rtl/hp_walker.sv
// Walk controller: current state, byte index within the header, validity byte,
// header byte count and the done/error pulses.
// Assumes in_sop is only meaningful together with in_valid; a sop restarts the walk.
module hp_walker
    import hp_pkg::*;
#(
    parameter int unsigned META_BYTES = 16,
    parameter int unsigned LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  hp_state_e        nxt_state,
    output hp_state_e        cur_state,
    output logic             beat,
    output logic [7:0]       hdr_vld,
    output logic             done,
    output logic             err,
    output logic [LEN_W-1:0] pkt_len
);
    localparam int unsigned MAX_HDR = (META_BYTES > LEN_IPV4) ? META_BYTES : LEN_IPV4;
    localparam int unsigned CNT_W   = $clog2(MAX_HDR);

    hp_state_e        state_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx, eff_cnt, last_idx;
    logic [7:0]       vld_q, vld_nx;
    logic [LEN_W-1:0] len_q, len_nx;
    logic             done_q, err_q;
    logic             sop_beat, in_hdr, last, finish, cut;

    // Effective position: a start-of-packet beat always begins the prefix.
    always_comb begin
        sop_beat  = in_valid && in_sop;
        cur_state = sop_beat ? ST_META : state_q;
        eff_cnt   = sop_beat ? '0 : cnt_q;
        in_hdr    = (cur_state != ST_IDLE) && (cur_state != ST_DRAIN);
        beat      = in_valid && in_hdr;
        last_idx  = CNT_W'(hdr_len(cur_state, META_BYTES) - 1);
        last      = beat && (eff_cnt == last_idx);
        finish    = last && (nxt_state == ST_DRAIN);
        cut       = beat && in_eop && !finish;
    end

    // Next walk position, validity byte and byte count.
    always_comb begin
        st_nx  = state_q;
        cnt_nx = cnt_q;
        vld_nx = sop_beat ? 8'h00 : vld_q;
        len_nx = sop_beat ? '0 : len_q;
        if (last) vld_nx = vld_nx | vbit(cur_state);
        if (beat) len_nx = len_nx + 1'b1;
        if (beat) begin
            if (cut) begin
                st_nx  = ST_IDLE;
                cnt_nx = '0;
            end else if (finish) begin
                st_nx  = in_eop ? ST_IDLE : ST_DRAIN;
                cnt_nx = '0;
            end else if (last) begin
                st_nx  = nxt_state;
                cnt_nx = '0;
            end else begin
                st_nx  = cur_state;
                cnt_nx = eff_cnt + 1'b1;
            end
        end else if (in_valid && in_eop && state_q == ST_DRAIN) begin
            st_nx = ST_IDLE;
        end
    end

    // Register the walk and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            vld_q   <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= st_nx;
            cnt_q   <= cnt_nx;
            vld_q   <= vld_nx;
            len_q   <= len_nx;
            done_q  <= finish || cut;
            err_q   <= cut;
        end
    end

    assign hdr_vld = vld_q;
    assign done    = done_q;
    assign err     = err_q;
    assign pkt_len = len_q;

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_q) && $stable(cnt_q)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);

    assert_one_transport_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_q[5:4]) && (!(vld_q[4] || vld_q[5]) || vld_q[3]));

    assert_one_pre_eth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_q[1:0]));

    assert_eth_after_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[2] |-> vld_q[6]);

    generate
        if (META_BYTES > 1) begin : g_sop_chk
            assert_sop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_sop) |=> (vld_q == 8'h00));
        end
    endgenerate

endmodule

// File: rtl/hp_parser.sv
// Top of the header parser: walk controller, branch logic and one capture
// register per header. Assumes a byte-wide stream with a metadata prefix
// at the head of every packet.
module hp_parser
    import hp_pkg::*;
#(
    parameter int unsigned META_BYTES   = 16,
    parameter int unsigned SEL_BYTE     = 12,
    parameter int unsigned PORT_BIT_OFS = 7,
    parameter int unsigned PORT_W       = 9,
    parameter int unsigned CPU_PORT     = 320,
    parameter int unsigned LEN_W        = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic [7:0]               in_byte,
    output logic [7:0]               hdr_vld,
    output logic [8*LEN_INJ-1:0]     hdr_inj,
    output logic [8*LEN_CPU-1:0]     hdr_cpu,
    output logic [8*LEN_ETH-1:0]     hdr_eth,
    output logic [8*LEN_IPV4-1:0]    hdr_ipv4,
    output logic [8*LEN_TCP-1:0]     hdr_tcp,
    output logic [8*LEN_UDP-1:0]     hdr_udp,
    output logic                     done,
    output logic                     parse_err,
    output logic [LEN_W-1:0]         parse_len
);
    hp_state_e cur_state, nxt_state;
    logic      beat;

    logic [8*META_BYTES-1:0] meta_q, meta_nx;
    logic [8*LEN_INJ-1:0]    inj_nx;
    logic [8*LEN_CPU-1:0]    cpu_nx;
    logic [8*LEN_ETH-1:0]    eth_nx;
    logic [8*LEN_IPV4-1:0]   ipv4_nx;
    logic [8*LEN_TCP-1:0]    tcp_nx;
    logic [8*LEN_UDP-1:0]    udp_nx;
    logic                    unused_tail;

    assign unused_tail = ^{meta_q, inj_nx, cpu_nx, tcp_nx, udp_nx};

    hp_walker #(.META_BYTES(META_BYTES), .LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .nxt_state(nxt_state), .cur_state(cur_state), .beat(beat),
        .hdr_vld(hdr_vld), .done(done), .err(parse_err), .pkt_len(parse_len)
    );

    hp_branch #(
        .META_BYTES(META_BYTES), .SEL_BYTE(SEL_BYTE), .PORT_BIT_OFS(PORT_BIT_OFS),
        .PORT_W(PORT_W), .CPU_PORT(CPU_PORT)
    ) u_branch (
        .cur(cur_state), .meta_full(meta_nx), .eth_full(eth_nx),
        .ipv4_full(ipv4_nx), .nxt(nxt_state)
    );

    hp_capture #(.BYTES(META_BYTES)) u_cap_meta (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_META),
        .din(in_byte), .q(meta_q), .q_next(meta_nx));

    hp_capture #(.BYTES(LEN_INJ)) u_cap_inj (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_INJ),
        .din(in_byte), .q(hdr_inj), .q_next(inj_nx));

    hp_capture #(.BYTES(LEN_CPU)) u_cap_cpu (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_CPU),
        .din(in_byte), .q(hdr_cpu), .q_next(cpu_nx));

    hp_capture #(.BYTES(LEN_ETH)) u_cap_eth (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_ETH),
        .din(in_byte), .q(hdr_eth), .q_next(eth_nx));

    hp_capture #(.BYTES(LEN_IPV4)) u_cap_ipv4 (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_IPV4),
        .din(in_byte), .q(hdr_ipv4), .q_next(ipv4_nx));

    hp_capture #(.BYTES(LEN_TCP)) u_cap_tcp (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_TCP),
        .din(in_byte), .q(hdr_tcp), .q_next(tcp_nx));

    hp_capture #(.BYTES(LEN_UDP)) u_cap_udp (
        .clk(clk), .rst_n(rst_n), .en(beat && cur_state == ST_UDP),
        .din(in_byte), .q(hdr_udp), .q_next(udp_nx));

endmodule

// File: tb/test_hp_parser.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes a predicted result per packet,
// the monitor pops it on every done pulse and compares.
module test_hp_parser;
    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0]   hdr_vld;
    logic [15:0]  hdr_inj, hdr_cpu, parse_len;
    logic [111:0] hdr_eth;
    logic [159:0] hdr_ipv4, hdr_tcp;
    logic [63:0]  hdr_udp;
    logic done, parse_err;

    always #4 clk = ~clk;

    hp_parser i_hp_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .hdr_vld(hdr_vld),
        .hdr_inj(hdr_inj), .hdr_cpu(hdr_cpu), .hdr_eth(hdr_eth),
        .hdr_ipv4(hdr_ipv4), .hdr_tcp(hdr_tcp), .hdr_udp(hdr_udp),
        .done(done), .parse_err(parse_err), .parse_len(parse_len));

    typedef logic [7:0] bq_t [$];
    typedef struct packed {
        logic [7:0]   vld;
        logic [15:0]  len;
        logic         err;
        logic [15:0]  inj;
        logic [15:0]  cpu;
        logic [111:0] eth;
        logic [159:0] ipv4;
        logic [159:0] tcp;
        logic [63:0]  udp;
    } exp_t;

    exp_t expq[$];
    exp_t last_e, mon_e;
    int vectors = 0, miscompares = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void put_fill(ref bq_t q, input int n, input int seed);
        for (int i = 0; i < n; i++) q.push_back(8'((seed * 13 + i * 29 + 5) & 255));
    endfunction

    function automatic void put_meta(ref bq_t q, input logic [8:0] port,
                                     input logic [7:0] sel, input int seed);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            b = 8'((seed + i * 17 + 1) & 255);
            if (i == 0)  b[0] = port[8];
            if (i == 1)  b = port[7:0];
            if (i == 12) b = sel;
            q.push_back(b);
        end
    endfunction

    function automatic void put_eth(ref bq_t q, input logic [15:0] etype, input int seed);
        put_fill(q, 12, seed);
        q.push_back(etype[15:8]);
        q.push_back(etype[7:0]);
    endfunction

    function automatic void put_ipv4(ref bq_t q, input logic [7:0] proto,
                                     input logic [12:0] frag, input int seed);
        for (int i = 0; i < 20; i++) begin
            logic [7:0] b;
            b = 8'((seed * 7 + i * 11 + 3) & 255);
            if (i == 6) b = {b[7:5], frag[12:8]};
            if (i == 7) b = frag[7:0];
            if (i == 9) b = proto;
            q.push_back(b);
        end
    endfunction

    // Prediction from the requirements: walk the packet bytes.
    function automatic exp_t model(input bq_t q);
        exp_t e;
        int n, pos, st, len;
        logic [159:0] h;
        logic [8:0] port;
        e = '0;
        n = q.size();
        if (n < 16) begin
            e.err = 1'b1; e.len = 16'(n);
            return e;
        end
        e.vld[6] = 1'b1;
        pos = 16;
        port = {q[0][0], q[1]};
        if (q[12] == 8'd0)     st = 1;
        else if (port == 320)  st = 2;
        else                   st = 3;
        while (st != 0) begin
            case (st)
                1, 2: len = 2;
                3: len = 14;
                4, 5: len = 20;
                default: len = 8;
            endcase
            if (pos + len > n) begin
                e.err = 1'b1; e.len = 16'(n);
                return e;
            end
            h = '0;
            for (int i = 0; i < len; i++) h = {h[151:0], q[pos + i]};
            case (st)
                1: begin e.inj = h[15:0]; e.vld[0] = 1'b1; st = 3; end
                2: begin e.cpu = h[15:0]; e.vld[1] = 1'b1; st = 3; end
                3: begin
                    e.eth = h[111:0]; e.vld[2] = 1'b1;
                    st = ({q[pos+12], q[pos+13]} == 16'h0800) ? 4 : 0;
                end
                4: begin
                    e.ipv4 = h; e.vld[3] = 1'b1;
                    if ({q[pos+6][4:0], q[pos+7]} != 13'd0) st = 0;
                    else if (q[pos+9] == 8'd6)  st = 5;
                    else if (q[pos+9] == 8'd17) st = 6;
                    else st = 0;
                end
                5: begin e.tcp = h; e.vld[4] = 1'b1; st = 0; end
                default: begin e.udp = h[63:0]; e.vld[5] = 1'b1; st = 0; end
            endcase
            pos += len;
        end
        e.len = 16'(pos);
        return e;
    endfunction

    // Compare the captured headers that the prediction marks valid.
    task automatic cmp_fields(input exp_t e, input string when);
        if (e.vld[0]) chk("R2", {when, " injected header"}, 160'(hdr_inj), 160'(e.inj));
        if (e.vld[1]) chk("R3", {when, " cpu header"}, 160'(hdr_cpu), 160'(e.cpu));
        if (e.vld[2]) chk("R4", {when, " ethernet"}, 160'(hdr_eth), 160'(e.eth));
        if (e.vld[3]) chk("R5", {when, " ipv4"}, hdr_ipv4, e.ipv4);
        if (e.vld[4]) chk("R6", {when, " tcp"}, hdr_tcp, e.tcp);
        if (e.vld[5]) chk("R5", {when, " udp"}, 160'(hdr_udp), 160'(e.udp));
    endtask

    // Monitor: every done pulse pops one prediction.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk("R7", "unexpected done", 160'(1), 160'(0));
            end else begin
                mon_e = expq.pop_front();
                chk("R2", "validity byte", 160'(hdr_vld), 160'(mon_e.vld));
                chk("R7", "parsed length", 160'(parse_len), 160'(mon_e.len));
                chk("R8", "error flag", 160'(parse_err), 160'(mon_e.err));
                cmp_fields(mon_e, "at done");
            end
        end
    end

    // Driver: push the prediction, stream the bytes, then confirm outputs held.
    task automatic send(input bq_t q, input bit gaps, input bit chk_clear);
        exp_t e;
        e = model(q);
        expq.push_back(e);
        last_e = e;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            if (i == 1 && chk_clear) chk("R10", "validity after sop", 160'(hdr_vld), 160'(0));
            if (gaps && (i % 3 == 2)) begin
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == q.size() - 1);
            in_byte  = q[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "done seen for packet", 160'(expq.size()), 160'(0));
        chk("R9", "validity held after packet", 160'(hdr_vld), 160'(e.vld));
        cmp_fields(e, "after payload R9");
    endtask

    // Bytes without a start-of-packet must not disturb anything.
    task automatic send_stray(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == n - 1);
            in_byte = 8'(i * 37 + 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "validity after stray bytes", 160'(hdr_vld), 160'(last_e.vld));
        cmp_fields(last_e, "after stray R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        bq_t p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset validity", 160'(hdr_vld), 160'(0));
        chk("R1", "reset done", 160'(done), 160'(0));
        chk("R1", "reset error", 160'(parse_err), 160'(0));
        chk("R1", "reset length", 160'(parse_len), 160'(0));

        // Injected header, IPv4/TCP, payload afterwards.
        p = {}; put_meta(p, 9'h07, 8'h00, 1); put_fill(p, 2, 2); put_eth(p, 16'h0800, 3);
        put_ipv4(p, 8'd6, 13'd0, 4); put_fill(p, 20, 5); put_fill(p, 6, 6);
        send(p, 1'b0, 1'b0);

        // CPU port: packet ends on the last UDP byte.
        p = {}; put_meta(p, 9'h140, 8'h5A, 7); put_fill(p, 2, 8); put_eth(p, 16'h0800, 9);
        put_ipv4(p, 8'd17, 13'd0, 10); put_fill(p, 8, 11);
        send(p, 1'b0, 1'b1);

        // Port 321 goes straight to Ethernet; fragment offset blocks TCP.
        p = {}; put_meta(p, 9'h141, 8'h01, 12); put_eth(p, 16'h0800, 13);
        put_ipv4(p, 8'd6, 13'h100, 14); put_fill(p, 3, 15);
        send(p, 1'b0, 1'b1);

        // Port with the CPU port's low byte only; non-IPv4 EtherType.
        p = {}; put_meta(p, 9'h040, 8'h22, 16); put_eth(p, 16'h86DD, 17); put_fill(p, 4, 18);
        send(p, 1'b0, 1'b1);

        // Unknown protocol; UDP with fragment offset.
        p = {}; put_meta(p, 9'h003, 8'h09, 19); put_eth(p, 16'h0800, 20);
        put_ipv4(p, 8'd99, 13'd0, 21); put_fill(p, 2, 22);
        send(p, 1'b0, 1'b1);
        p = {}; put_meta(p, 9'h003, 8'h09, 23); put_eth(p, 16'h0800, 24);
        put_ipv4(p, 8'd17, 13'd1, 25); put_fill(p, 8, 26);
        send(p, 1'b0, 1'b1);

        // R8: truncated inside IPv4.
        p = {}; put_meta(p, 9'h010, 8'h03, 27); put_eth(p, 16'h0800, 28); put_fill(p, 10, 29);
        send(p, 1'b0, 1'b1);

        // R8: end exactly on the Ethernet boundary while IPv4 is still expected.
        p = {}; put_meta(p, 9'h010, 8'h03, 30); put_eth(p, 16'h0800, 31);
        send(p, 1'b0, 1'b1);

        // R8: packet shorter than the prefix.
        p = {}; put_fill(p, 5, 32);
        send(p, 1'b0, 1'b1);

        // R9: stalls throughout a TCP packet.
        p = {}; put_meta(p, 9'h140, 8'h33, 33); put_fill(p, 2, 34); put_eth(p, 16'h0800, 35);
        put_ipv4(p, 8'd6, 13'd0, 36); put_fill(p, 20, 37); put_fill(p, 5, 38);
        send(p, 1'b1, 1'b1);

        // R9: stray bytes with no start-of-packet.
        send_stray(7);

        // R10 and R2: injected header after a stalled UDP packet.
        p = {}; put_meta(p, 9'h1FF, 8'h00, 39); put_fill(p, 2, 40); put_eth(p, 16'h0800, 41);
        put_ipv4(p, 8'd17, 13'd0, 42); put_fill(p, 8, 43); put_fill(p, 1, 44);
        send(p, 1'b1, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule